// File: doc/BRIEF.md
# Bus Cycle Break Condition Matcher

This block watches a stream of bus cycles and raises a single-clock break pulse when a cycle fits the conditions held in its own condition register. Each cycle arrives with a valid strobe and four attributes: which master issued it (processor or DMA engine), whether it is an instruction fetch or a data access, whether it reads or writes, and its operand size. The condition register splits into four two-bit fields, one per attribute. In every field, code 00 turns off comparison for that attribute.

Software programs the register through a simple write/read port. Only the low eight bits hold state. The upper eight always read as zero, and writes to them are dropped. A small two-state channel machine tracks whether any field is enabled. In state CH_OFF (all fields 00) the channel never matches. In state CH_ARMED at least one field is enabled. A write whose low byte is zero takes the transition DISARM to CH_OFF. A write whose low byte is non-zero takes the transition ARM to CH_ARMED. Any other cycle takes the transition HOLD. Reset enters CH_OFF.

Top module: `brk_match`

## Requirements
- R1: After reset, reg_rdata reads 0x0000 and brk_hit is 0.
- R2: reg_rdata[15:8] always reads 0, whatever was written to reg_wdata[15:8].
- R3: reg_rdata[7:0] returns the last value written to reg_wdata[7:0].
- R4: Master field, bits 7:6. Code 00 ignores the master. Code 01 matches only cyc_dma=0 (processor). Codes 10 and 11 match only cyc_dma=1 (DMA).
- R5: Cycle-type field, bits 5:4. Code 00 ignores the type. Code 01 matches only cyc_fetch=1. Code 10 matches only cyc_fetch=0. Code 11 matches either.
- R6: Direction field, bits 3:2. Code 00 ignores the direction. Code 01 matches only cyc_write=0. Codes 10 and 11 match only cyc_write=1.
- R7: Size field, bits 1:0. Code 00 ignores the size. Otherwise the field matches only when cyc_size equals the field value. Size codes are 01 byte, 10 word and 11 longword; a cycle with cyc_size 00 never satisfies an enabled size field.
- R8: When bits 7:0 are all zero, brk_hit never asserts.
- R9: brk_hit is 1 for exactly the clock after a cycle with cyc_valid=1 that satisfies every enabled field. It is 0 after any cycle with cyc_valid=0.
- R10: A register write affects only bus cycles presented on later clocks. A cycle presented in the same clock as the write is compared against the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr_en | input | 1 | Condition register write strobe |
| reg_wdata | input | 16 | Condition register write data |
| reg_rdata | output | 16 | Condition register read value |
| cyc_valid | input | 1 | Bus cycle present this clock |
| cyc_dma | input | 1 | Master: 0 processor, 1 DMA |
| cyc_fetch | input | 1 | 1 instruction fetch, 0 data access |
| cyc_write | input | 1 | 1 write, 0 read |
| cyc_size | input | 2 | Operand size code |
| brk_hit | output | 1 | Registered break-match pulse |

## Verification
On every clock the assertions check four things. The reserved read bits stay zero. A pulse never appears without a valid cycle on the clock before, and never appears while the register was all-zero. Any pulse respects the master, direction and size fields that were set when the cycle was sampled. Only the bench scenarios can show three other things: that a fitting cycle actually produces a pulse, the either-type code, and the old-value comparison when a write and a cycle share a clock. They do this against a reference model of the field decoding.

// File: rtl/brk_pkg.sv
package brk_pkg;
    localparam int REG_W  = 16;
    localparam int LIVE_W = 8;
    localparam int FLD_W  = 2;

    typedef enum logic {CH_OFF, CH_ARMED} ch_state_e;

    typedef struct packed {
        logic [FLD_W-1:0] master;
        logic [FLD_W-1:0] kind;
        logic [FLD_W-1:0] dir;
        logic [FLD_W-1:0] size;
    } cond_t;

    localparam logic [FLD_W-1:0] FLD_NONE = '0;
endpackage

// File: rtl/brk_cond_reg.sv
module brk_cond_reg
    import brk_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int LW = LIVE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [LW-1:0] wdata_live,
    output cond_t         cond,
    output logic [RW-1:0] rdata
);
    localparam int RSV_W = RW - LW;

    logic [LW-1:0] live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            live_q <= '0;
        else if (wr_en)
            live_q <= wdata_live;
    end

    assign cond  = cond_t'(live_q);
    assign rdata = {{RSV_W{1'b0}}, live_q};
endmodule

// File: rtl/brk_field_cmp.sv
module brk_field_cmp
    import brk_pkg::*;
(
    input  cond_t            cond,
    input  logic             cyc_dma,
    input  logic             cyc_fetch,
    input  logic             cyc_write,
    input  logic [FLD_W-1:0] cyc_size,
    output logic             all_ok
);
    logic ok_master, ok_kind, ok_dir, ok_size;

    always_comb begin
        unique case (cond.master)
            2'b00:        ok_master = 1'b1;
            2'b01:        ok_master = !cyc_dma;
            default:      ok_master = cyc_dma;
        endcase

        unique case (cond.kind)
            2'b00:        ok_kind = 1'b1;
            2'b01:        ok_kind = cyc_fetch;
            2'b10:        ok_kind = !cyc_fetch;
            default:      ok_kind = 1'b1;
        endcase

        unique case (cond.dir)
            2'b00:        ok_dir = 1'b1;
            2'b01:        ok_dir = !cyc_write;
            default:      ok_dir = cyc_write;
        endcase

        if (cond.size == FLD_NONE)
            ok_size = 1'b1;
        else
            ok_size = (cyc_size == cond.size);

        all_ok = ok_master && ok_kind && ok_dir && ok_size;
    end
endmodule

// File: rtl/brk_match.sv
module brk_match
    import brk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             cyc_valid,
    input  logic             cyc_dma,
    input  logic             cyc_fetch,
    input  logic             cyc_write,
    input  logic [FLD_W-1:0] cyc_size,
    output logic             brk_hit
);
    cond_t     cond;
    logic      fields_ok;
    ch_state_e state_q, state_d;
    logic      hit_q;
    logic      unused_rsv;

    assign unused_rsv = ^reg_wdata[REG_W-1:LIVE_W];

    brk_cond_reg #(.RW(REG_W), .LW(LIVE_W)) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .wdata_live (reg_wdata[LIVE_W-1:0]),
        .cond       (cond),
        .rdata      (reg_rdata)
    );

    brk_field_cmp u_cmp (
        .cond      (cond),
        .cyc_dma   (cyc_dma),
        .cyc_fetch (cyc_fetch),
        .cyc_write (cyc_write),
        .cyc_size  (cyc_size),
        .all_ok    (fields_ok)
    );

    // next-state: ARM / DISARM on writes, HOLD otherwise
    always_comb begin
        state_d = state_q;
        if (reg_wr_en)
            state_d = (reg_wdata[LIVE_W-1:0] != '0) ? CH_ARMED : CH_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= CH_OFF;
        else
            state_q <= state_d;
    end

    // output process: compare against the register as held before any write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
        end else begin
            unique case (state_q)
                CH_OFF:   hit_q <= 1'b0;
                CH_ARMED: hit_q <= cyc_valid && fields_ok;
                default:  hit_q <= 1'b0;
            endcase
        end
    end

    assign brk_hit = hit_q;
endmodule

// File: rtl/brk_match_chk.sv
module brk_match_chk
    import brk_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] reg_rdata,
    input logic             cyc_valid,
    input logic             cyc_dma,
    input logic             cyc_write,
    input logic [FLD_W-1:0] cyc_size,
    input logic             brk_hit
);
    AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:LIVE_W] == '0); // R2

    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        brk_hit |-> $past(cyc_valid)); // R9

    AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        brk_hit |-> ($past(reg_rdata[LIVE_W-1:0]) != '0)); // R8

    AST_MASTER_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_hit && $past(reg_rdata[7:6]) == 2'b01) |-> !$past(cyc_dma)); // R4

    AST_MASTER_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_hit && $past(reg_rdata[7])) |-> $past(cyc_dma)); // R4

    AST_DIR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_hit && $past(reg_rdata[3:2]) != 2'b00) |-> ($past(cyc_write) == $past(reg_rdata[3]))); // R6

    AST_SIZE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_hit && $past(reg_rdata[1:0]) != 2'b00) |-> ($past(cyc_size) == $past(reg_rdata[1:0]))); // R7
endmodule

bind brk_match brk_match_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rdata (reg_rdata),
    .cyc_valid (cyc_valid),
    .cyc_dma   (cyc_dma),
    .cyc_write (cyc_write),
    .cyc_size  (cyc_size),
    .brk_hit   (brk_hit)
);

// File: tb/brk_match_bench.sv
module brk_match_bench;
    localparam time CLK_P = 8ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        cyc_valid = 1'b0;
    logic        cyc_dma = 1'b0;
    logic        cyc_fetch = 1'b0;
    logic        cyc_write = 1'b0;
    logic [1:0]  cyc_size = '0;
    logic        brk_hit;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] mreg = '0;

    always #(CLK_P/2) clk = ~clk;

    brk_match u_brk_match (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cyc_valid(cyc_valid), .cyc_dma(cyc_dma), .cyc_fetch(cyc_fetch),
        .cyc_write(cyc_write), .cyc_size(cyc_size), .brk_hit(brk_hit)
    );

    function automatic logic model_hit(input logic [7:0] r, input logic v, input logic d,
                                       input logic f, input logic w, input logic [1:0] s);
        logic ok;
        if (!v || r == 8'h00) return 1'b0;
        ok = 1'b1;
        if (r[7:6] == 2'b01 && d) ok = 1'b0;          // R4
        if (r[7] && !d) ok = 1'b0;                    // R4
        if (r[5:4] == 2'b01 && !f) ok = 1'b0;         // R5
        if (r[5:4] == 2'b10 && f) ok = 1'b0;          // R5
        if (r[3:2] == 2'b01 && w) ok = 1'b0;          // R6
        if (r[3] && !w) ok = 1'b0;                    // R6
        if (r[1:0] != 2'b00 && s != r[1:0]) ok = 1'b0; // R7
        return ok;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, check at the following negedge
    task automatic step(input logic we, input logic [15:0] wd, input logic v,
                        input logic d, input logic f, input logic w, input logic [1:0] s,
                        input string req);
        logic e;
        reg_wr_en = we; reg_wdata = wd;
        cyc_valid = v; cyc_dma = d; cyc_fetch = f; cyc_write = w; cyc_size = s;
        e = model_hit(mreg, v, d, f, w, s);   // R10: old register value
        if (we) mreg = wd[7:0];
        @(negedge clk);
        check({req, " hit"}, {15'h0, brk_hit}, {15'h0, e});
        check("R2/R3 rdata", reg_rdata, {8'h00, mreg});
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        check("R1 rdata", reg_rdata, 16'h0000);
        check("R1 hit", {15'h0, brk_hit}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: disabled channel never matches
        step(0, 0, 1, 0, 1, 0, 2'b01, "R8");
        step(0, 0, 1, 1, 0, 1, 2'b11, "R8");
        // R2: reserved write bits dropped
        step(1, 16'hFF00, 0, 0, 0, 0, 0, "R2");
        step(0, 0, 1, 0, 0, 0, 2'b10, "R8");
        // R10: write with same-clock cycle uses old (all-zero) register
        step(1, 16'h0040, 1, 0, 0, 0, 2'b01, "R10");
        step(0, 0, 1, 0, 0, 0, 2'b01, "R4 cpu");
        step(0, 0, 1, 1, 0, 0, 2'b01, "R4 cpu vs dma");
        // R4: master code 11 behaves as DMA
        step(1, 16'h00C0, 0, 0, 0, 0, 0, "R3");
        step(0, 0, 1, 1, 1, 1, 2'b11, "R4 dma");
        step(0, 0, 1, 0, 1, 1, 2'b11, "R4 dma vs cpu");
        // R5: either-type code
        step(1, 16'h0030, 0, 0, 0, 0, 0, "R3");
        step(0, 0, 1, 0, 1, 0, 2'b00, "R5 fetch");
        step(0, 0, 1, 0, 0, 0, 2'b00, "R5 data");
        step(0, 0, 0, 0, 0, 0, 2'b00, "R9 no valid");
        // R6 / R7
        step(1, 16'h000B, 0, 0, 0, 0, 0, "R3");
        step(0, 0, 1, 0, 0, 1, 2'b11, "R6 R7 write long");
        step(0, 0, 1, 0, 0, 0, 2'b11, "R6 read rejected");
        step(0, 0, 1, 0, 0, 1, 2'b00, "R7 size 00 rejected");
        // R8: disarm
        step(1, 16'h5A00, 1, 0, 0, 1, 2'b11, "R10");
        step(0, 0, 1, 0, 0, 1, 2'b11, "R8 off");

        for (int i = 0; i < 4000; i++) begin
            logic we;
            logic [15:0] wd;
            we = ($urandom % 8) == 0;
            wd = $urandom;
            step(we, wd, ($urandom % 4) != 0, $urandom, $urandom, $urandom,
                 2'($urandom), "R4-field R5 R6 R7 R9");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule